// File: doc/BRIEF.md
# Packed Ternary Dot-Product Engine

The engine forms the integer dot product of one row of ternary weights (each weight is -1, 0 or +1) with a vector of signed 8-bit activations. It has no multiplier. Each weight picks one of three actions for its matching activation: add it to a 32-bit signed accumulator, subtract it, or leave the accumulator alone. Weights arrive packed into small code words, one code word per cycle. The activations those weights cover arrive on a parallel bus in the same cycle, so the two streams stay in lockstep.

A parameter selects one of two packings. The dense packing puts three weights into a 5-bit base-3 code. The pair packing puts two weights into a 4-bit code made of two 2-bit halves. A run begins with a start pulse. After the parameterised number of groups has been consumed, the engine raises a one-cycle done strobe and holds the final sum on its result port. Rescaling the result, tiling across rows and memory handling belong to the surrounding datapath.

Top module: `tern_dot_engine`

## Requirements
- R1: After reset, result is 0, done is 0 and code_err is 0.
- R2: A start pulse makes result 0 and code_err 0 from the next cycle on. It begins a new run even when one is in progress, and a group presented in the same cycle as start is not accumulated.
- R3: In dense mode (PACK_MODE=0) a code c in 0..26 is read as c = d0 + 3*d1 + 9*d2. Each digit maps 0 to weight -1, 1 to weight 0 and 2 to weight +1. Digit d0 applies to grp_acts[7:0], d1 to grp_acts[15:8] and d2 to grp_acts[23:16].
- R4: Each accepted group adds to result the sum, over its lanes, of the signed activation taken as +a, -a or 0 according to the lane's weight. Result is a 32-bit two's-complement value.
- R5: In dense mode, codes 27 to 31 set code_err and add nothing to result, but still count as one group. code_err stays set until the next start.
- R6: In pair mode (PACK_MODE=1), grp_code[1:0] is the weight for grp_acts[7:0] and grp_code[3:2] is the weight for grp_acts[15:8]. The encodings are 00 for 0, 01 for +1 and 11 for -1. The value 10 is illegal: it sets code_err and that weight counts as 0.
- R7: A run consumes VEC_LEN/LANES groups, where LANES is 3 in dense mode and 2 in pair mode. done is high for exactly the one cycle after the clock edge that accepts the last group, and result then holds the final sum.
- R8: A group is accepted only when grp_valid is high during a run. Cycles with grp_valid low, and groups presented after done and before the next start, leave result and code_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the accumulator and opens a run |
| grp_valid | input | 1 | The current weight group and its activations are present |
| grp_code | input | 5 (4 in pair mode) | Packed ternary weight group |
| grp_acts | input | 24 (16 in pair mode) | Signed 8-bit activations for the group, lane 0 in the low byte |
| result | output | 32 | Signed running and final dot product |
| done | output | 1 | One-cycle strobe after the last group is accepted |
| code_err | output | 1 | An illegal weight code was seen in this run |

## Verification
Every output is a register, so the effect of a group or of a start pulse shows up in the cycle that follows the edge that sampled it. The bench drives inputs on the falling edge and compares on the next falling edge, which puts every check exactly one edge after its stimulus. It compares result against a running reference sum after every group, so an error in a single group is caught where it happens. The done strobe is checked high on the last group's follow-up cycle and low one cycle later. Idle cycles, groups arriving outside a run and mid-run restarts are each compared one edge later, to show that nothing moved.

// File: rtl/tern_pkg.sv
package tern_pkg;
    // Lane count per packed group for each packing variant
    function automatic int lanes_for(input int pack_mode);
        return (pack_mode == 0) ? 3 : 2;
    endfunction

    function automatic int code_bits_for(input int pack_mode);
        return (pack_mode == 0) ? 5 : 4;
    endfunction

    localparam logic [1:0] PAIR_ZERO = 2'b00;
    localparam logic [1:0] PAIR_POS  = 2'b01;
    localparam logic [1:0] PAIR_BAD  = 2'b10;
    localparam logic [1:0] PAIR_NEG  = 2'b11;
endpackage

// File: rtl/tern_unpack.sv
module tern_unpack #(
    parameter int PACK_MODE = 0,
    parameter int LANES     = 3,
    parameter int CODE_W    = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [LANES-1:0]  add_en,
    output logic [LANES-1:0]  sub_en,
    output logic              bad
);
    import tern_pkg::*;

    generate
        if (PACK_MODE == 0) begin : g_base3
            logic [4:0] quot1;
            logic [4:0] quot2;
            logic [1:0] dig [3];

            always_comb begin
                quot1  = code / 5'd3;
                quot2  = quot1 / 5'd3;
                dig[0] = 2'(code  % 5'd3);
                dig[1] = 2'(quot1 % 5'd3);
                dig[2] = 2'(quot2);
                bad    = (code > 5'd26);
                for (int i = 0; i < 3; i++) begin
                    add_en[i] = !bad && (dig[i] == 2'd2);
                    sub_en[i] = !bad && (dig[i] == 2'd0);
                end
            end
        end else begin : g_pair
            logic [LANES-1:0] half_bad;
            for (genvar i = 0; i < LANES; i++) begin : g_half
                always_comb begin
                    add_en[i]   = (code[2*i +: 2] == PAIR_POS);
                    sub_en[i]   = (code[2*i +: 2] == PAIR_NEG);
                    half_bad[i] = (code[2*i +: 2] == PAIR_BAD);
                end
            end
            assign bad = |half_bad;
        end
    endgenerate
endmodule

// File: rtl/tern_select_sum.sv
module tern_select_sum #(
    parameter int LANES = 3,
    parameter int ACT_W = 8,
    parameter int SUM_W = ACT_W + $clog2(LANES) + 1
) (
    input  logic [LANES*ACT_W-1:0]   acts,
    input  logic [LANES-1:0]         add_en,
    input  logic [LANES-1:0]         sub_en,
    output logic signed [SUM_W-1:0]  sum
);
    logic signed [SUM_W-1:0] term [LANES];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic signed [SUM_W-1:0] ext;
            always_comb begin
                ext = SUM_W'($signed(acts[i*ACT_W +: ACT_W]));
                if (add_en[i])      term[i] = ext;
                else if (sub_en[i]) term[i] = -ext;
                else                term[i] = '0;
                // a weight is never both +1 and -1
                assert (!(add_en[i] && sub_en[i])); // R4
            end
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) sum = sum + term[i];
    end
endmodule

// File: rtl/tern_dot_engine.sv
module tern_dot_engine #(
    parameter int PACK_MODE = 0,
    parameter int VEC_LEN   = 96,
    parameter int ACT_W     = 8,
    parameter int ACC_W     = 32,
    localparam int LANES    = tern_pkg::lanes_for(PACK_MODE),
    localparam int CODE_W   = tern_pkg::code_bits_for(PACK_MODE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    grp_valid,
    input  logic [CODE_W-1:0]       grp_code,
    input  logic [LANES*ACT_W-1:0]  grp_acts,
    output logic [ACC_W-1:0]        result,
    output logic                    done,
    output logic                    code_err
);
    localparam int GROUPS = VEC_LEN / LANES;
    localparam int CNT_W  = $clog2(GROUPS + 1);
    localparam int SUM_W  = ACT_W + $clog2(LANES) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
        logic             err;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic [LANES-1:0]        add_en, sub_en;
    logic                    grp_bad;
    logic signed [SUM_W-1:0] grp_sum;

    tern_unpack #(
        .PACK_MODE (PACK_MODE),
        .LANES     (LANES),
        .CODE_W    (CODE_W)
    ) u_unpack (
        .code   (grp_code),
        .add_en (add_en),
        .sub_en (sub_en),
        .bad    (grp_bad)
    );

    tern_select_sum #(
        .LANES (LANES),
        .ACT_W (ACT_W),
        .SUM_W (SUM_W)
    ) u_sum (
        .acts   (grp_acts),
        .add_en (add_en),
        .sub_en (sub_en),
        .sum    (grp_sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.acc  = '0;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.err  = 1'b0;
        end else if (st_q.busy && grp_valid) begin
            st_d.acc = st_q.acc + {{(ACC_W-SUM_W){grp_sum[SUM_W-1]}}, grp_sum};
            st_d.err = st_q.err | grp_bad;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(GROUPS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result   = st_q.acc;
    assign done     = st_q.done;
    assign code_err = st_q.err;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (result == '0 && !code_err)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !grp_valid) |=> ($stable(result) && $stable(code_err))); // R8

    AST_BAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && grp_valid && PACK_MODE == 0 && grp_code > CODE_W'(26)) |=> $stable(result)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (code_err && !start) |=> code_err); // R5
endmodule

// File: tb/tern_dot_engine_test.sv
`timescale 1ns/1ps
module tern_dot_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // dense instance
    logic        st3 = 0, v3 = 0;
    logic [4:0]  c3 = '0;
    logic [23:0] a3 = '0;
    logic [31:0] r3;
    logic        dn3, er3;

    // pair instance
    logic        st2 = 0, v2 = 0;
    logic [3:0]  c2 = '0;
    logic [15:0] a2 = '0;
    logic [31:0] r2;
    logic        dn2, er2;

    tern_dot_engine #(.PACK_MODE(0), .VEC_LEN(96)) uut (
        .clk(clk), .rst_n(rst_n), .start(st3), .grp_valid(v3),
        .grp_code(c3), .grp_acts(a3), .result(r3), .done(dn3), .code_err(er3));

    tern_dot_engine #(.PACK_MODE(1), .VEC_LEN(96)) uut_pair (
        .clk(clk), .rst_n(rst_n), .start(st2), .grp_valid(v2),
        .grp_code(c2), .grp_acts(a2), .result(r2), .done(dn2), .code_err(er2));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int actv(input int g, input int i);
        logic [7:0] b;
        b = 8'((g * 53 + i * 97 + 11) & 255);
        return int'($signed(b));
    endfunction

    function automatic int w_base3(input int code, input int lane);
        int d;
        if (code > 26) return 0;
        d = (lane == 0) ? code % 3 : (lane == 1) ? (code / 3) % 3 : code / 9;
        return d - 1;
    endfunction

    function automatic int w_pair(input int code, input int lane);
        int h;
        h = (code >> (2 * lane)) & 3;
        return (h == 1) ? 1 : (h == 3) ? -1 : 0;
    endfunction

    task automatic start3();
        st3 = 1; @(negedge clk); st3 = 0;
        chk(r3 == 0 && !er3, "R2 dense start clears", int'(r3), 0);
    endtask

    task automatic start2();
        st2 = 1; @(negedge clk); st2 = 0;
        chk(r2 == 0 && !er2, "R2 pair start clears", int'(r2), 0);
    endtask

    // kind 0: codes 0..31 sweep; 1: all +1 at -128; 2: all -1 with idle gaps
    task automatic run3(input int kind);
        int exp = 0;
        bit eexp = 0;
        start3();
        for (int g = 0; g < 32; g++) begin
            int code, a [3];
            code = (kind == 0) ? g : (kind == 1) ? 26 : 0;
            for (int i = 0; i < 3; i++) a[i] = (kind == 1) ? -128 : actv(g, i);
            if (kind == 2) begin
                v3 = 0; c3 = 5'(g); a3 = 24'hABCDEF;
                @(negedge clk);
                chk(r3 == 32'(exp), "R8 idle cycle holds result", int'(r3), exp);
            end
            v3 = 1; c3 = 5'(code);
            a3 = {8'(a[2]), 8'(a[1]), 8'(a[0])};
            for (int i = 0; i < 3; i++) exp += w_base3(code, i) * a[i];
            if (code > 26) eexp = 1;
            @(negedge clk);
            chk(r3 == 32'(exp), (code > 26) ? "R5 illegal code skipped" : "R3 R4 dense group sum",
                int'(r3), exp);
            chk(dn3 == (g == 31), "R7 done timing", int'(dn3), int'(g == 31));
            chk(er3 == eexp, "R5 error flag", int'(er3), int'(eexp));
        end
        v3 = 0;
        @(negedge clk);
        chk(!dn3, "R7 done is one cycle", int'(dn3), 0);
        // groups after done are ignored
        v3 = 1; c3 = 5'd26; a3 = 24'h7F7F7F;
        @(negedge clk);
        v3 = 0;
        chk(r3 == 32'(exp), "R8 group after done ignored", int'(r3), exp);
        chk(er3 == eexp && !dn3, "R8 no error or done after run", int'(er3), int'(eexp));
    endtask

    task automatic run2(input bit legal_only);
        int exp = 0;
        bit eexp = 0;
        int legal [9] = '{0, 1, 3, 4, 5, 7, 12, 13, 15};
        start2();
        for (int g = 0; g < 48; g++) begin
            int code, a [2];
            code = legal_only ? legal[g % 9] : g % 16;
            for (int i = 0; i < 2; i++) a[i] = actv(g + 7, i);
            v2 = 1; c2 = 4'(code);
            a2 = {8'(a[1]), 8'(a[0])};
            for (int i = 0; i < 2; i++) begin
                exp += w_pair(code, i) * a[i];
                if (((code >> (2 * i)) & 3) == 2) eexp = 1;
            end
            @(negedge clk);
            chk(r2 == 32'(exp), "R6 pair group sum", int'(r2), exp);
            chk(er2 == eexp, "R6 pair illegal half flag", int'(er2), int'(eexp));
            chk(dn2 == (g == 47), "R7 pair done timing", int'(dn2), int'(g == 47));
        end
        v2 = 0;
        @(negedge clk);
        chk(!dn2, "R7 pair done is one cycle", int'(dn2), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(r3 == 0 && r2 == 0, "R1 reset result", int'(r3), 0);
        chk(!dn3 && !dn2, "R1 reset done", int'(dn3), 0);
        chk(!er3 && !er2, "R1 reset code_err", int'(er3), 0);
        rst_n = 1;
        @(negedge clk);

        run3(0);
        run3(1);
        run3(2);

        // restart mid-run; group presented with start is dropped
        start3();
        for (int g = 0; g < 5; g++) begin
            v3 = 1; c3 = 5'd26; a3 = 24'h050505;
            @(negedge clk);
        end
        chk(r3 == 75, "R4 partial run sum", int'(r3), 75);
        st3 = 1; v3 = 1; c3 = 5'd31;
        @(negedge clk);
        st3 = 0; v3 = 0;
        chk(r3 == 0 && !er3, "R2 restart mid-run clears", int'(r3), 0);
        @(negedge clk);
        chk(r3 == 0 && !dn3, "R2 group with start not accumulated", int'(r3), 0);

        run2(1'b0);
        run2(1'b1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule